// File: doc/BRIEF.md
# TDM Timeslot Interface

This block frames a 2.048 Mb/s serial link of 32 timeslots and moves bytes between that link and three parallel byte ports. The bit clock `clk` runs at twice the data rate, so each bit cell lasts two clock cycles. A frame of 32 slots of 8 bits is therefore 512 cycles long, which gives 125 µs and an 8 kHz frame rate at the nominal 4.096 MHz clock. A frame starts when `fp_n` is sampled low at an active clock edge. That edge resets the position counter to slot 0, bit 0, first half-cell. Timeslot 1 carries a control/status byte. Timeslots 2 and 3 carry the two PCM voice bytes, called A and B.

Transmit bits change only at the start of a bit cell. Receive bits are sampled at the second edge of the cell. Bytes travel most significant bit first. When a port is disabled, the control slot tri-states the line, while the PCM slots drive zeros. A received control byte is always delivered. A PCM byte is delivered only when its slot is enabled. If both PCM enables are set, only slot 2 (port A) is active, and slot 3 is treated as disabled.

The slot state machine has five states. `ST_HUNT` is the state after reset. `ST_GAP` covers any unused slot. `ST_CTRL`, `ST_PCM_A` and `ST_PCM_B` cover slots 1, 2 and 3. The transitions are as follows:
- The frame-start transition goes from any state to `ST_GAP` whenever `fp_n` is low.
- The slot-advance transition happens at the last cycle of each slot and selects the state of the next slot: 0→1 `ST_GAP`→`ST_CTRL`, 1→2 `ST_CTRL`→`ST_PCM_A`, 2→3 `ST_PCM_A`→`ST_PCM_B`, and 3→4 `ST_PCM_B`→`ST_GAP`.
- The frame wrap from slot 31 to slot 0 stays in `ST_GAP` and keeps the frame running without a pulse.
- `ST_HUNT` is left only by the frame-start transition.

Top module: `tdm_slot_if`

## Requirements
- R1: After reset and until the first frame pulse, `tx_oe` is low, no valid strobe rises and all received bytes read zero.
- R2: With the edge at which `fp_n` is sampled low as cycle -1, timeslot s bit b occupies cycles 16s+2b and 16s+2b+1. `tx_ser` and `tx_oe` hold the same value in both cycles of a cell.
- R3: With `ctrl_en` high, slot 1 drives `tx_oe` high and sends the control transmit byte, bit 7 first.
- R4: With `ctrl_en` low, `tx_oe` is low for all of slot 1.
- R5: The slot 1 receive byte, sampled MSB first at the second cycle of each cell, appears on `ctrl_rx_byte` with `ctrl_rx_vld` high in cycle 32. This happens regardless of `ctrl_en`.
- R6: During slots 2 and 3, `tx_oe` is high. A disabled PCM slot sends all zeros.
- R7: An enabled PCM slot sends its transmit byte MSB first. Its receive byte appears with its strobe in cycle 48 (port A) or cycle 64 (port B).
- R8: When both PCM enables are high, slot 3 sends zeros and gives no port-B strobe, while slot 2 behaves as enabled.
- R9: In every slot other than 1, 2 and 3, `tx_oe` is low.
- R10: Each transmit byte is sampled at the edge that starts the slot before its own. Later changes within that frame do not alter what is sent.
- R11: Each valid strobe is high for exactly one cycle, and at most one strobe is high at a time.
- R12: A disabled PCM slot gives no strobe and leaves its received-byte output unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fp_n | input | 1 | Active-low frame pulse |
| rx_ser | input | 1 | Serial receive data |
| tx_ser | output | 1 | Serial transmit data |
| tx_oe | output | 1 | Transmit output enable, low means tri-state |
| ctrl_en | input | 1 | Enable for the control slot (slot 1) |
| pcm_a_en | input | 1 | Enable for PCM slot A (slot 2) |
| pcm_b_en | input | 1 | Enable for PCM slot B (slot 3) |
| ctrl_tx_byte | input | 8 | Control byte to send |
| pcm_a_tx_byte | input | 8 | PCM A byte to send |
| pcm_b_tx_byte | input | 8 | PCM B byte to send |
| ctrl_rx_byte | output | 8 | Last received control byte |
| ctrl_rx_vld | output | 1 | One-cycle strobe for a new control byte |
| pcm_a_rx_byte | output | 8 | Last received PCM A byte |
| pcm_a_rx_vld | output | 1 | One-cycle strobe for a new PCM A byte |
| pcm_b_rx_byte | output | 8 | Last received PCM B byte |
| pcm_b_rx_vld | output | 1 | One-cycle strobe for a new PCM B byte |

## Verification
Any fault in the position counter or the slot state shows up at the ports within the first active slot after a frame pulse. An off-by-one position moves the rise of `tx_oe` away from cycle 16 and breaks the two-cycle cell pattern at once. A wrong half-cell phase shifts every received byte by one bit, which is first visible at the control strobe in cycle 32. A state machine stuck in hunt, or a wrong fallback decode between the two PCM slots, shows up no later than cycle 64 as a missing strobe, an extra strobe, or nonzero data in a slot that should carry zeros.

// File: rtl/tdm_pkg.sv
package tdm_pkg;

    // Slot-level state of the framing engine
    typedef enum logic [2:0] {
        ST_HUNT  = 3'd0,
        ST_GAP   = 3'd1,
        ST_CTRL  = 3'd2,
        ST_PCM_A = 3'd3,
        ST_PCM_B = 3'd4
    } slot_state_e;

    localparam int unsigned NUM_PORTS = 3;

endpackage

// File: rtl/tdm_frame_fsm.sv
module tdm_frame_fsm
    import tdm_pkg::*;
#(
    parameter int unsigned SLOTS     = 32,
    parameter int unsigned BYTE_W    = 8,
    parameter int unsigned CTRL_SLOT = 1,
    localparam int unsigned SLOT_W   = $clog2(SLOTS),
    localparam int unsigned BIT_W    = $clog2(BYTE_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fp_n,
    output slot_state_e       state_q,
    output logic              ph_q,
    output logic [BIT_W-1:0]  bit_q,
    output logic              slot_enter,
    output logic [SLOT_W-1:0] slot_next,
    output logic              byte_done,
    output logic              rx_sample
);

    localparam logic [BIT_W-1:0]  LAST_BIT  = BIT_W'(BYTE_W - 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = SLOT_W'(SLOTS - 1);

    logic [SLOT_W-1:0] slot_q, slot_d;
    logic [BIT_W-1:0]  bit_d;
    logic              ph_d;
    slot_state_e       state_d;
    logic              in_slot;

    function automatic slot_state_e slot_decode(input logic [SLOT_W-1:0] s);
        if (s == SLOT_W'(CTRL_SLOT))          return ST_CTRL;
        else if (s == SLOT_W'(CTRL_SLOT + 1)) return ST_PCM_A;
        else if (s == SLOT_W'(CTRL_SLOT + 2)) return ST_PCM_B;
        else                                  return ST_GAP;
    endfunction

    // Next position and next state
    always_comb begin
        slot_d  = slot_q;
        bit_d   = bit_q;
        ph_d    = ph_q;
        state_d = state_q;
        if (!fp_n) begin
            slot_d  = '0;
            bit_d   = '0;
            ph_d    = 1'b0;
            state_d = slot_decode(SLOT_W'(0));
        end else if (state_q != ST_HUNT) begin
            ph_d = ~ph_q;
            if (ph_q) begin
                if (bit_q == LAST_BIT) begin
                    bit_d  = '0;
                    slot_d = (slot_q == LAST_SLOT) ? '0 : slot_q + 1'b1;
                end else begin
                    bit_d = bit_q + 1'b1;
                end
            end
            state_d = slot_decode(slot_d);
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_HUNT;
            slot_q  <= '0;
            bit_q   <= '0;
            ph_q    <= 1'b0;
        end else begin
            state_q <= state_d;
            slot_q  <= slot_d;
            bit_q   <= bit_d;
            ph_q    <= ph_d;
        end
    end

    // Timing strobes for the data paths
    always_comb begin
        in_slot    = (state_q == ST_CTRL) || (state_q == ST_PCM_A) || (state_q == ST_PCM_B);
        slot_enter = (state_d != ST_HUNT) && !ph_d && (bit_d == '0);
        slot_next  = slot_d;
        rx_sample  = fp_n && in_slot && ph_q;
        byte_done  = rx_sample && (bit_q == LAST_BIT);
    end

endmodule

// File: rtl/tdm_tx_path.sv
module tdm_tx_path
    import tdm_pkg::*;
#(
    parameter int unsigned SLOTS     = 32,
    parameter int unsigned BYTE_W    = 8,
    parameter int unsigned CTRL_SLOT = 1,
    localparam int unsigned SLOT_W   = $clog2(SLOTS),
    localparam int unsigned BIT_W    = $clog2(BYTE_W)
) (
    input  logic                               clk,
    input  logic                               rst_n,
    input  slot_state_e                        state_q,
    input  logic [BIT_W-1:0]                   bit_q,
    input  logic                               slot_enter,
    input  logic [SLOT_W-1:0]                  slot_next,
    input  logic                               ctrl_en,
    input  logic                               pcm_a_en,
    input  logic                               pcm_b_live,
    input  logic [NUM_PORTS-1:0][BYTE_W-1:0]   tx_bytes,
    output logic                               tx_ser,
    output logic                               tx_oe
);

    logic [NUM_PORTS-1:0][BYTE_W-1:0] hold_q;
    logic [BIT_W-1:0]                 idx;

    // Each port's byte is captured when the slot ahead of its own begins
    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_hold
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                hold_q[g] <= '0;
            end else if (slot_enter && (slot_next == SLOT_W'(CTRL_SLOT - 1 + g))) begin
                hold_q[g] <= tx_bytes[g];
            end
        end
    end

    // Output process: MSB first, selected by the slot state
    always_comb begin
        idx    = BIT_W'(BYTE_W - 1) - bit_q;
        tx_oe  = 1'b0;
        tx_ser = 1'b0;
        unique case (state_q)
            ST_CTRL: begin
                tx_oe  = ctrl_en;
                tx_ser = ctrl_en & hold_q[0][idx];
            end
            ST_PCM_A: begin
                tx_oe  = 1'b1;
                tx_ser = pcm_a_en & hold_q[1][idx];
            end
            ST_PCM_B: begin
                tx_oe  = 1'b1;
                tx_ser = pcm_b_live & hold_q[2][idx];
            end
            ST_HUNT, ST_GAP: begin
                tx_oe  = 1'b0;
                tx_ser = 1'b0;
            end
            default: begin
                tx_oe  = 1'b0;
                tx_ser = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/tdm_rx_path.sv
module tdm_rx_path
    import tdm_pkg::*;
#(
    parameter int unsigned BYTE_W = 8
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  slot_state_e                      state_q,
    input  logic                             rx_sample,
    input  logic                             byte_done,
    input  logic                             rx_ser,
    input  logic                             pcm_a_en,
    input  logic                             pcm_b_live,
    output logic [NUM_PORTS-1:0][BYTE_W-1:0] rx_bytes,
    output logic [NUM_PORTS-1:0]             rx_vld
);

    logic [BYTE_W-1:0]    sh_q;
    logic [BYTE_W-1:0]    full_byte;
    logic [NUM_PORTS-1:0] take;

    always_comb begin
        full_byte = {sh_q[BYTE_W-2:0], rx_ser};
        take[0]   = (state_q == ST_CTRL);
        take[1]   = (state_q == ST_PCM_A) && pcm_a_en;
        take[2]   = (state_q == ST_PCM_B) && pcm_b_live;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sh_q <= '0;
        end else if (rx_sample) begin
            sh_q <= full_byte;
        end
    end

    for (genvar g = 0; g < NUM_PORTS; g++) begin : g_port
        logic [BYTE_W-1:0] byte_q;
        logic              vld_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                byte_q <= '0;
                vld_q  <= 1'b0;
            end else begin
                vld_q <= byte_done && take[g];
                if (byte_done && take[g]) begin
                    byte_q <= full_byte;
                end
            end
        end
        assign rx_bytes[g] = byte_q;
        assign rx_vld[g]   = vld_q;
    end

endmodule

// File: rtl/tdm_slot_if.sv
module tdm_slot_if
    import tdm_pkg::*;
#(
    parameter int unsigned SLOTS     = 32,
    parameter int unsigned BYTE_W    = 8,
    parameter int unsigned CTRL_SLOT = 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fp_n,
    input  logic              rx_ser,
    output logic              tx_ser,
    output logic              tx_oe,
    input  logic              ctrl_en,
    input  logic              pcm_a_en,
    input  logic              pcm_b_en,
    input  logic [BYTE_W-1:0] ctrl_tx_byte,
    input  logic [BYTE_W-1:0] pcm_a_tx_byte,
    input  logic [BYTE_W-1:0] pcm_b_tx_byte,
    output logic [BYTE_W-1:0] ctrl_rx_byte,
    output logic              ctrl_rx_vld,
    output logic [BYTE_W-1:0] pcm_a_rx_byte,
    output logic              pcm_a_rx_vld,
    output logic [BYTE_W-1:0] pcm_b_rx_byte,
    output logic              pcm_b_rx_vld
);

    localparam int unsigned SLOT_W = $clog2(SLOTS);
    localparam int unsigned BIT_W  = $clog2(BYTE_W);

    slot_state_e                      slot_state;
    logic                             cell_phase;
    logic [BIT_W-1:0]                 bit_pos;
    logic                             slot_enter;
    logic [SLOT_W-1:0]                slot_next;
    logic                             byte_done;
    logic                             rx_sample;
    logic                             pcm_b_live;
    logic [NUM_PORTS-1:0][BYTE_W-1:0] tx_bytes;
    logic [NUM_PORTS-1:0][BYTE_W-1:0] rx_bytes;
    logic [NUM_PORTS-1:0]             rx_vld;

    // Slot 3 yields to slot 2 when both PCM enables are set
    assign pcm_b_live = pcm_b_en & ~pcm_a_en;
    assign tx_bytes   = {pcm_b_tx_byte, pcm_a_tx_byte, ctrl_tx_byte};

    tdm_frame_fsm #(
        .SLOTS(SLOTS), .BYTE_W(BYTE_W), .CTRL_SLOT(CTRL_SLOT)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .fp_n       (fp_n),
        .state_q    (slot_state),
        .ph_q       (cell_phase),
        .bit_q      (bit_pos),
        .slot_enter (slot_enter),
        .slot_next  (slot_next),
        .byte_done  (byte_done),
        .rx_sample  (rx_sample)
    );

    tdm_tx_path #(
        .SLOTS(SLOTS), .BYTE_W(BYTE_W), .CTRL_SLOT(CTRL_SLOT)
    ) u_tx (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_q    (slot_state),
        .bit_q      (bit_pos),
        .slot_enter (slot_enter),
        .slot_next  (slot_next),
        .ctrl_en    (ctrl_en),
        .pcm_a_en   (pcm_a_en),
        .pcm_b_live (pcm_b_live),
        .tx_bytes   (tx_bytes),
        .tx_ser     (tx_ser),
        .tx_oe      (tx_oe)
    );

    tdm_rx_path #(
        .BYTE_W(BYTE_W)
    ) u_rx (
        .clk        (clk),
        .rst_n      (rst_n),
        .state_q    (slot_state),
        .rx_sample  (rx_sample),
        .byte_done  (byte_done),
        .rx_ser     (rx_ser),
        .pcm_a_en   (pcm_a_en),
        .pcm_b_live (pcm_b_live),
        .rx_bytes   (rx_bytes),
        .rx_vld     (rx_vld)
    );

    assign ctrl_rx_byte  = rx_bytes[0];
    assign pcm_a_rx_byte = rx_bytes[1];
    assign pcm_b_rx_byte = rx_bytes[2];
    assign ctrl_rx_vld   = rx_vld[0];
    assign pcm_a_rx_vld  = rx_vld[1];
    assign pcm_b_rx_vld  = rx_vld[2];

endmodule

// File: rtl/tdm_slot_if_chk.sv
module tdm_slot_if_chk
    import tdm_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input slot_state_e state,
    input logic        cell_phase,
    input logic        tx_ser,
    input logic        tx_oe,
    input logic        ctrl_en,
    input logic        pcm_a_en,
    input logic        pcm_b_en,
    input logic        ctrl_rx_vld,
    input logic        pcm_a_rx_vld,
    input logic        pcm_b_rx_vld
);

    AST_HUNT_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_HUNT) |-> (!tx_oe && !ctrl_rx_vld && !pcm_a_rx_vld && !pcm_b_rx_vld)); // R1

    AST_CELL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        cell_phase |-> ($stable(tx_ser) && $stable(tx_oe))); // R2

    AST_CTRL_OFF_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_CTRL) && !ctrl_en) |-> !tx_oe); // R4

    AST_CTRL_STROBE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rx_vld |=> !ctrl_rx_vld); // R5

    AST_PCM_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_PCM_A) || (state == ST_PCM_B)) |-> tx_oe); // R6

    AST_FALLBACK_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_PCM_B) && pcm_a_en) |-> !tx_ser); // R8

    AST_B_STROBE_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        pcm_b_rx_vld |-> ($past(pcm_b_en) && !$past(pcm_a_en))); // R8

    AST_GAP_TRISTATE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_GAP) |-> !tx_oe); // R9

    AST_STROBE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_rx_vld, pcm_a_rx_vld, pcm_b_rx_vld})); // R11

    AST_PCM_STROBE_SHORT: assert property (@(posedge clk) disable iff (!rst_n)
        (pcm_a_rx_vld || pcm_b_rx_vld) |=> !(pcm_a_rx_vld || pcm_b_rx_vld)); // R11

endmodule

bind tdm_slot_if tdm_slot_if_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .state        (slot_state),
    .cell_phase   (cell_phase),
    .tx_ser       (tx_ser),
    .tx_oe        (tx_oe),
    .ctrl_en      (ctrl_en),
    .pcm_a_en     (pcm_a_en),
    .pcm_b_en     (pcm_b_en),
    .ctrl_rx_vld  (ctrl_rx_vld),
    .pcm_a_rx_vld (pcm_a_rx_vld),
    .pcm_b_rx_vld (pcm_b_rx_vld)
);

// File: tb/tdm_slot_if_tb_top.sv
`timescale 1ns/1ps
module tdm_slot_if_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       fp_n = 1'b1;
    logic       rx_ser = 1'b0;
    logic       tx_ser, tx_oe;
    logic       ctrl_en = 1'b0, pcm_a_en = 1'b0, pcm_b_en = 1'b0;
    logic [7:0] ctrl_tx_byte = '0, pcm_a_tx_byte = '0, pcm_b_tx_byte = '0;
    logic [7:0] ctrl_rx_byte, pcm_a_rx_byte, pcm_b_rx_byte;
    logic       ctrl_rx_vld, pcm_a_rx_vld, pcm_b_rx_vld;

    always #2.5 clk = ~clk;

    tdm_slot_if dut_i (
        .clk(clk), .rst_n(rst_n), .fp_n(fp_n), .rx_ser(rx_ser),
        .tx_ser(tx_ser), .tx_oe(tx_oe),
        .ctrl_en(ctrl_en), .pcm_a_en(pcm_a_en), .pcm_b_en(pcm_b_en),
        .ctrl_tx_byte(ctrl_tx_byte), .pcm_a_tx_byte(pcm_a_tx_byte), .pcm_b_tx_byte(pcm_b_tx_byte),
        .ctrl_rx_byte(ctrl_rx_byte), .ctrl_rx_vld(ctrl_rx_vld),
        .pcm_a_rx_byte(pcm_a_rx_byte), .pcm_a_rx_vld(pcm_a_rx_vld),
        .pcm_b_rx_byte(pcm_b_rx_byte), .pcm_b_rx_vld(pcm_b_rx_vld)
    );

    int  n_checks = 0;
    int  n_errs   = 0;
    bit  finished = 1'b0;

    typedef struct packed {
        logic [1:0] port;
        logic [7:0] val;
    } item_t;

    item_t      exp_q[$];
    logic [7:0] last_rx [3] = '{8'h00, 8'h00, 8'h00};
    logic [2:0] prev_vld = 3'b000;

    task automatic chk(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errs++;
            $display("FAIL %s: got %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic pop_cmp(input int p, input logic [7:0] got);
        item_t it;
        string tag;
        tag = (p == 0) ? "R5" : "R7";
        if (exp_q.size() == 0) begin
            chk((p == 0) ? "R5" : "R12", 1, 0);
        end else begin
            it = exp_q.pop_front();
            chk(tag, p, int'(it.port));
            chk(tag, got, it.val);
        end
    endtask

    // Monitor: compares each delivered byte against the scoreboard queue
    always @(negedge clk) begin
        logic [2:0] vnow;
        vnow = {pcm_b_rx_vld, pcm_a_rx_vld, ctrl_rx_vld};
        if (rst_n && (vnow != 3'b000)) begin
            chk("R11", int'($countones(vnow) <= 1), 1);
            chk("R11", int'(|(vnow & prev_vld)), 0);
            if (vnow[0]) pop_cmp(0, ctrl_rx_byte);
            if (vnow[1]) pop_cmp(1, pcm_a_rx_byte);
            if (vnow[2]) pop_cmp(2, pcm_b_rx_byte);
        end
        prev_vld = rst_n ? vnow : 3'b000;
    end

    // Driver: one full frame, entered and left just after a falling clock edge
    task automatic run_frame(input bit ce, input bit ae, input bit be, input bit scr,
                             input logic [7:0] ctx, input logic [7:0] atx, input logic [7:0] btx,
                             input logic [7:0] crx, input logic [7:0] arx, input logic [7:0] brx);
        int         s, b;
        bit         e_oe, e_d, bl;
        logic [1:0] cell_val;
        logic [7:0] a_sent;
        string      tag;
        bl     = be && !ae;
        a_sent = scr ? (atx ^ 8'h5A) : atx;
        cell_val = 2'b00;
        ctrl_en = ce; pcm_a_en = ae; pcm_b_en = be;
        ctrl_tx_byte = ctx; pcm_a_tx_byte = atx; pcm_b_tx_byte = btx;
        fp_n = 1'b0;
        exp_q.push_back(item_t'{2'd0, crx});
        last_rx[0] = crx;
        if (ae) begin exp_q.push_back(item_t'{2'd1, arx}); last_rx[1] = arx; end
        if (bl) begin exp_q.push_back(item_t'{2'd2, brx}); last_rx[2] = brx; end
        @(posedge clk);
        for (int k = 0; k < 512; k++) begin
            @(negedge clk);
            fp_n = 1'b1;
            s = k / 16;
            b = (k % 16) / 2;
            if (k % 2 == 0) begin
                if (s == 1)      rx_ser = crx[7-b];
                else if (s == 2) rx_ser = arx[7-b];
                else if (s == 3) rx_ser = brx[7-b];
                else             rx_ser = k[3] ^ k[6];
            end
            if (scr && k == 4) begin
                ctrl_tx_byte  = ~ctx;
                pcm_a_tx_byte = a_sent;
            end
            if (scr && k == 34) begin
                ctrl_tx_byte  = 8'hC3;
                pcm_a_tx_byte = 8'h3C;
                pcm_b_tx_byte = ~btx;
            end
            case (s)
                1: begin e_oe = ce;   e_d = ctx[7-b];           tag = scr ? "R10" : (ce ? "R3" : "R4"); end
                2: begin e_oe = 1'b1; e_d = ae && a_sent[7-b];  tag = scr ? "R10" : (ae ? "R7" : "R6"); end
                3: begin e_oe = 1'b1; e_d = bl && btx[7-b];     tag = (ae && be) ? "R8" : (be ? "R7" : "R6"); end
                default: begin e_oe = 1'b0; e_d = 1'b0;         tag = "R9"; end
            endcase
            chk(tag, tx_oe, e_oe);
            if (e_oe) chk(tag, tx_ser, e_d);
            if (k % 2 == 0) cell_val = {tx_oe, tx_ser};
            else            chk("R2", {tx_oe, tx_ser}, cell_val);
            if (k == 32) chk("R5", ctrl_rx_vld, 1);
            if (k == 48) chk(ae ? "R7" : "R12", pcm_a_rx_vld, ae);
            if (k == 64) chk((ae && be) ? "R8" : (be ? "R7" : "R12"), pcm_b_rx_vld, bl);
        end
        chk("R5", ctrl_rx_byte, last_rx[0]);
        chk(ae ? "R7" : "R12", pcm_a_rx_byte, last_rx[1]);
        chk(bl ? "R7" : "R12", pcm_b_rx_byte, last_rx[2]);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        chk("R1", tx_oe, 0);
        rst_n = 1'b1;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            chk("R1", tx_oe, 0);
            chk("R1", {ctrl_rx_vld, pcm_a_rx_vld, pcm_b_rx_vld}, 0);
        end
        chk("R1", {ctrl_rx_byte, pcm_a_rx_byte, pcm_b_rx_byte}, 0);

        run_frame(1'b0, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h0F, 8'hF0, 8'h96, 8'h3C, 8'hC3);
        run_frame(1'b1, 1'b1, 1'b0, 1'b0, 8'h81, 8'h7E, 8'h55, 8'h1B, 8'hE4, 8'h99);
        run_frame(1'b1, 1'b0, 1'b1, 1'b0, 8'h6D, 8'h12, 8'hB4, 8'h70, 8'h0E, 8'h2D);
        run_frame(1'b0, 1'b1, 1'b1, 1'b0, 8'h44, 8'hC9, 8'h3A, 8'h8F, 8'h51, 8'hA6);
        run_frame(1'b1, 1'b1, 1'b0, 1'b1, 8'h29, 8'hD2, 8'h77, 8'h5C, 8'h0B, 8'hE1);

        repeat (20) @(negedge clk);
        chk("R7", exp_q.size(), 0);
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            n_checks++;
            n_errs++;
            $display("FAIL watchdog: got 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errs);
            $finish;
        end
    end

endmodule